// File: doc/BRIEF.md
# Line-Chunking DMA Sequencer

This block sits between a DMA requester and a cache-line memory port. It takes one byte-granular transfer at a time on an upstream valid/ready port: a start address, a byte count of at most `MAX_BYTES`, a direction, a flag saying whether an answer is wanted, and the full write payload. It then walks the transfer as a series of line-sized pieces on a downstream port. The first piece is trimmed so that it ends at a line boundary, and every later piece begins on one. The block sends one piece, waits for that piece's completion strobe (a write acknowledge, or returning line data on a read), and only then sends the next piece. After the last piece completes, the block returns to idle and, if the requester asked for one, raises a one-cycle response carrying the gathered read bytes.

Upstream requests that arrive while a transfer is running are refused; nothing is queued. The refusal is remembered, and the requester gets a one-cycle retry strobe as soon as the block is free. A drain strobe is answered with a drain-done pulse. That pulse comes on the next cycle if nothing is in flight, and otherwise on the cycle after the running transfer finishes. A zero-byte request is consumed, produces no downstream traffic and is flagged as illegal.

The controller has three states. `ST_IDLE` goes to `ST_ISSUE` when a non-empty request is accepted. `ST_ISSUE` presents a piece and goes to `ST_WAIT` when the piece is accepted. `ST_WAIT` goes back to `ST_ISSUE` when the completion strobe leaves bytes still to move, and to `ST_IDLE` when it covers the final byte.

Top module: `dma_line_splitter`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `ds_valid`, `rsp_valid`, `retry_pulse`, `drain_done` and `req_bad` are 0.
- R2: Only one transfer runs at a time. `req_ready` is 0 from the cycle after acceptance until the final piece completes. A request offered in that window is refused and not stored.
- R3: The first piece is addressed at the request address. Its length is min(total, LINE_BYTES − (address mod LINE_BYTES)). `ds_be` bit b is set for byte lanes b in [offset, offset+length).
- R4: Each later piece is addressed at start + bytes completed, which is line-aligned. Its length is min(remaining, LINE_BYTES), and its enables start at lane 0.
- R5: `ds_write` is 1 for a store and 0 for a load. Payload byte k of the transfer appears in `ds_wdata` lane (k − completed + offset) of the piece that carries it. A whole transfer therefore lands byte-exact in memory.
- R6: For a read, the bytes taken from `ds_rdata` start at the in-line offset for the first piece and at lane 0 for later pieces. Byte k of the transfer appears at `rsp_rdata[8k+7:8k]`.
- R7: A new piece is presented only after the previous piece's `ds_done`. The transfer ends on the `ds_done` that brings the completed count to the total.
- R8: While `ds_valid` is 1 and `ds_ready` is 0, the piece (address, length, enables, data, direction) holds unchanged in the next cycle.
- R9: A refused request causes exactly one `retry_pulse`, in the cycle after the final piece completes. This includes a refusal in that same completion cycle.
- R10: `rsp_valid` pulses for one cycle, the cycle after the final completion, and only when `req_need_rsp` was 1 at acceptance. `req_ready` is already 1 in that cycle.
- R11: `drain_req` while idle gives `drain_done` the next cycle. `drain_req` during a transfer, up to and including its completion cycle, gives `drain_done` the cycle after completion.
- R12: An accepted request with `req_len` = 0 moves no data, gives `req_bad` the next cycle and no `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Upstream request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_need_rsp | input | 1 | Requester wants a response |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte count, 0..MAX_BYTES |
| req_wdata | input | MAX_BYTES*8 | Write payload, byte k at bits 8k+7:8k |
| rsp_valid | output | 1 | One-cycle completion response |
| rsp_rdata | output | MAX_BYTES*8 | Gathered read bytes |
| retry_pulse | output | 1 | One-cycle strobe to a refused requester |
| req_bad | output | 1 | One-cycle strobe for a zero-length request |
| ds_valid | output | 1 | Downstream piece offered |
| ds_ready | input | 1 | Downstream piece accepted |
| ds_write | output | 1 | Piece is a store |
| ds_addr | output | ADDR_W | Piece byte address |
| ds_len | output | LB_W | Piece byte count |
| ds_be | output | LINE_BYTES | Byte-lane enables within the line |
| ds_wdata | output | LINE_BYTES*8 | Line-lane write data |
| ds_done | input | 1 | Piece completed (ack or read return) |
| ds_rdata | input | LINE_BYTES*8 | Whole line read data, valid with ds_done |
| drain_req | input | 1 | Drain request strobe |
| drain_done | output | 1 | Drain complete strobe |

## Verification
The final `ds_done` of a transfer can share its cycle with a second upstream request and with a drain strobe. The refusal and the drain must then be credited to the ending transfer, not lost and not pushed to the next one. The bench waits for the edge where its own model sees the completion strobe on the last outstanding byte. It raises `req_valid` and `drain_req` just after that strobe, so both are sampled on the completion edge. It then expects `retry_pulse`, `drain_done` and, where asked for, `rsp_valid` together in the following cycle, with `req_ready` already high so the refused request is accepted on the next edge.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int LEN_W      = 9,
    parameter int LB_W       = 7,
    parameter int OFF_W      = 6
) (
    input  logic [ADDR_W-1:0]     start_addr,
    input  logic [LEN_W-1:0]      total_len,
    input  logic [LEN_W-1:0]      done_cnt,
    output logic [ADDR_W-1:0]     chunk_addr,
    output logic [OFF_W-1:0]      chunk_off,
    output logic [LB_W-1:0]       chunk_len,
    output logic [LINE_BYTES-1:0] chunk_be
);

    int off_i;
    int room_i;
    int rem_i;
    int len_i;

    always_comb begin
        off_i  = (done_cnt == '0) ? int'(start_addr[OFF_W-1:0]) : 0;
        room_i = LINE_BYTES - off_i;
        rem_i  = int'(total_len) - int'(done_cnt);
        len_i  = (rem_i < room_i) ? rem_i : room_i;
        chunk_off  = OFF_W'(off_i);
        chunk_len  = LB_W'(len_i);
        chunk_addr = start_addr + ADDR_W'(done_cnt);
        for (int b = 0; b < LINE_BYTES; b++) begin
            chunk_be[b] = (b >= off_i) && (b < off_i + len_i);
        end
    end

endmodule

// File: rtl/dma_line_pack.sv
module dma_line_pack #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 256,
    parameter int LEN_W      = 9,
    parameter int OFF_W      = 6
) (
    input  logic [MAX_BYTES*8-1:0]  payload,
    input  logic [LEN_W-1:0]        done_cnt,
    input  logic [OFF_W-1:0]        chunk_off,
    input  logic [LINE_BYTES-1:0]   chunk_be,
    output logic [LINE_BYTES*8-1:0] line_wdata
);

    int idx;

    always_comb begin
        line_wdata = '0;
        idx = 0;
        for (int b = 0; b < LINE_BYTES; b++) begin
            idx = int'(done_cnt) + b - int'(chunk_off);
            if (chunk_be[b] && idx >= 0 && idx < MAX_BYTES) begin
                line_wdata[8*b +: 8] = payload[8*idx +: 8];
            end
        end
    end

endmodule

// File: rtl/dma_line_gather.sv
module dma_line_gather #(
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 256,
    parameter int LEN_W      = 9,
    parameter int OFF_W      = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    capture,
    input  logic [LINE_BYTES*8-1:0] line_rdata,
    input  logic [LEN_W-1:0]        done_cnt,
    input  logic [LEN_W-1:0]        issued_cnt,
    input  logic [OFF_W-1:0]        chunk_off,
    output logic [MAX_BYTES*8-1:0]  gathered
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gathered <= '0;
        end else if (clear) begin
            gathered <= '0;
        end else if (capture) begin
            for (int i = 0; i < MAX_BYTES; i++) begin
                if (i >= int'(done_cnt) && i < int'(issued_cnt)) begin
                    if ((i - int'(done_cnt) + int'(chunk_off)) < LINE_BYTES) begin
                        gathered[8*i +: 8] <=
                            line_rdata[8*(i - int'(done_cnt) + int'(chunk_off)) +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dma_side_flags.sv
module dma_side_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic refuse,
    input  logic drain_req,
    input  logic idle,
    input  logic finish,
    output logic retry_pulse,
    output logic drain_done
);

    logic retry_pend_q;
    logic draining_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            retry_pend_q <= 1'b0;
            draining_q   <= 1'b0;
            retry_pulse  <= 1'b0;
            drain_done   <= 1'b0;
        end else begin
            retry_pulse <= 1'b0;
            drain_done  <= 1'b0;
            if (finish) begin
                retry_pulse  <= retry_pend_q | refuse;
                retry_pend_q <= 1'b0;
                drain_done   <= draining_q | drain_req;
                draining_q   <= 1'b0;
            end else begin
                if (refuse) begin
                    retry_pend_q <= 1'b1;
                end
                if (drain_req && idle) begin
                    drain_done <= 1'b1;
                end else if (drain_req) begin
                    draining_q <= 1'b1;
                end
            end
        end
    end

    // R9: a retry strobe is never two cycles wide
    p_retry_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        retry_pulse |=> !retry_pulse);

    // R11: idle drain answers on the next cycle
    p_drain_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_req && idle) |=> drain_done);

    // R9: a refusal is eventually owed only while not idle
    p_pend_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refuse |-> !idle);

endmodule

// File: rtl/dma_line_splitter.sv
module dma_line_splitter
    import dma_split_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64,
    parameter int MAX_BYTES  = 256,
    parameter int LEN_W      = $clog2(MAX_BYTES + 1),
    parameter int LB_W       = $clog2(LINE_BYTES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic                    req_write,
    input  logic                    req_need_rsp,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [LEN_W-1:0]        req_len,
    input  logic [MAX_BYTES*8-1:0]  req_wdata,
    output logic                    rsp_valid,
    output logic [MAX_BYTES*8-1:0]  rsp_rdata,
    output logic                    retry_pulse,
    output logic                    req_bad,
    output logic                    ds_valid,
    input  logic                    ds_ready,
    output logic                    ds_write,
    output logic [ADDR_W-1:0]       ds_addr,
    output logic [LB_W-1:0]         ds_len,
    output logic [LINE_BYTES-1:0]   ds_be,
    output logic [LINE_BYTES*8-1:0] ds_wdata,
    input  logic                    ds_done,
    input  logic [LINE_BYTES*8-1:0] ds_rdata,
    input  logic                    drain_req,
    output logic                    drain_done
);

    localparam int OFF_W = $clog2(LINE_BYTES);

    seq_state_e state_q, state_d;

    logic [ADDR_W-1:0]      st_addr;
    logic [LEN_W-1:0]       st_len;
    logic                   st_write;
    logic                   st_need;
    logic [LEN_W-1:0]       done_q;
    logic [LEN_W-1:0]       issued_q;
    logic [MAX_BYTES*8-1:0] wbuf_q;
    logic                   rsp_q;
    logic                   bad_q;

    logic [OFF_W-1:0]       chunk_off;
    logic [LB_W-1:0]        chunk_len;

    logic accept, go, refuse, finish, capture;

    assign accept  = req_valid && req_ready;
    assign go      = accept && (req_len != '0);
    assign refuse  = req_valid && !req_ready;
    assign finish  = (state_q == ST_WAIT) && ds_done && (issued_q == st_len);
    assign capture = (state_q == ST_WAIT) && ds_done && !st_write;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (go)       state_d = ST_ISSUE;
            ST_ISSUE: if (ds_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (ds_done) state_d = finish ? ST_IDLE : ST_ISSUE;
            end
            default:  state_d = ST_IDLE;
        endcase
    end

    // state-decoded outputs
    always_comb begin
        req_ready = 1'b0;
        ds_valid  = 1'b0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: ds_valid  = 1'b1;
            ST_WAIT:  ;
            default:  ;
        endcase
    end

    // transfer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_addr  <= '0;
            st_len   <= '0;
            st_write <= 1'b0;
            st_need  <= 1'b0;
            done_q   <= '0;
            issued_q <= '0;
            wbuf_q   <= '0;
            rsp_q    <= 1'b0;
            bad_q    <= 1'b0;
        end else begin
            rsp_q <= finish && st_need;
            bad_q <= accept && (req_len == '0);
            if (go) begin
                st_addr  <= req_addr;
                st_len   <= req_len;
                st_write <= req_write;
                st_need  <= req_need_rsp;
                done_q   <= '0;
                issued_q <= '0;
                wbuf_q   <= req_wdata;
            end else if ((state_q == ST_ISSUE) && ds_ready) begin
                issued_q <= issued_q + LEN_W'(chunk_len);
            end else if ((state_q == ST_WAIT) && ds_done) begin
                done_q <= issued_q;
            end
        end
    end

    dma_chunk_calc #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W),
        .LB_W(LB_W), .OFF_W(OFF_W)
    ) u_calc (
        .start_addr(st_addr),
        .total_len (st_len),
        .done_cnt  (done_q),
        .chunk_addr(ds_addr),
        .chunk_off (chunk_off),
        .chunk_len (chunk_len),
        .chunk_be  (ds_be)
    );

    dma_line_pack #(
        .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .OFF_W(OFF_W)
    ) u_pack (
        .payload   (wbuf_q),
        .done_cnt  (done_q),
        .chunk_off (chunk_off),
        .chunk_be  (ds_be),
        .line_wdata(ds_wdata)
    );

    dma_line_gather #(
        .LINE_BYTES(LINE_BYTES), .MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .OFF_W(OFF_W)
    ) u_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (go),
        .capture   (capture),
        .line_rdata(ds_rdata),
        .done_cnt  (done_q),
        .issued_cnt(issued_q),
        .chunk_off (chunk_off),
        .gathered  (rsp_rdata)
    );

    dma_side_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .refuse     (refuse),
        .drain_req  (drain_req),
        .idle       (state_q == ST_IDLE),
        .finish     (finish),
        .retry_pulse(retry_pulse),
        .drain_done (drain_done)
    );

    assign ds_len    = chunk_len;
    assign ds_write  = st_write;
    assign rsp_valid = rsp_q;
    assign req_bad   = bad_q;

    // R2: upstream is closed while a piece is on offer
    p_one_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |-> !req_ready);

    // R8: an offered piece holds until taken
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_valid && !ds_ready) |=> (ds_valid && $stable(ds_addr) && $stable(ds_len)
                                     && $stable(ds_be) && $stable(ds_wdata)));

    // R4: pieces after the first start on a line boundary
    p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_valid && done_q != '0) |-> (ds_addr[OFF_W-1:0] == '0));

    // R3: every piece carries between one byte and a full line
    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ds_valid |-> (ds_len != '0 && int'(ds_len) <= LINE_BYTES
                      && $countones(ds_be) == int'(ds_len)));

    // R10: the response comes with the block already free
    p_rsp_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (req_ready && !ds_valid));

    // R12: zero-length acceptance flags illegal and issues nothing
    p_zero_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == '0) |=> (req_bad && !ds_valid && !rsp_valid));

    // R7: no piece is offered in the cycle after its predecessor was taken
    p_wait_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_valid && ds_ready) |=> !ds_valid);

endmodule

// File: tb/dma_line_splitter_bench.sv
module dma_line_splitter_bench;

    localparam int AW  = 32;
    localparam int LB  = 64;
    localparam int MB  = 256;
    localparam int LW  = 9;
    localparam int LBW = 7;
    localparam int MEMSZ = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic            req_need_rsp = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [LW-1:0]   req_len = '0;
    logic [MB*8-1:0] req_wdata = '0;
    logic            rsp_valid;
    logic [MB*8-1:0] rsp_rdata;
    logic            retry_pulse;
    logic            req_bad;
    logic            ds_valid;
    logic            ds_ready = 1'b0;
    logic            ds_write;
    logic [AW-1:0]   ds_addr;
    logic [LBW-1:0]  ds_len;
    logic [LB-1:0]   ds_be;
    logic [LB*8-1:0] ds_wdata;
    logic            ds_done = 1'b0;
    logic [LB*8-1:0] ds_rdata = '0;
    logic            drain_req = 1'b0;
    logic            drain_done;

    dma_line_splitter u_dma_line_splitter (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_need_rsp(req_need_rsp), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .retry_pulse(retry_pulse), .req_bad(req_bad),
        .ds_valid(ds_valid), .ds_ready(ds_ready), .ds_write(ds_write),
        .ds_addr(ds_addr), .ds_len(ds_len), .ds_be(ds_be), .ds_wdata(ds_wdata),
        .ds_done(ds_done), .ds_rdata(ds_rdata),
        .drain_req(drain_req), .drain_done(drain_done)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memories: mem is written through the block, gold directly from requests
    byte unsigned mem  [MEMSZ];
    byte unsigned gold [MEMSZ];

    // behavioural reference model
    bit m_busy = 0, m_issuing = 0, m_wr = 0, m_need = 0;
    bit m_retry = 0, m_drain = 0;
    bit e_rsp = 0, e_retry = 0, e_drain = 0, e_bad = 0;
    int m_start = 0, m_len = 0, m_done = 0, m_issued = 0;
    byte unsigned m_pay [MB];
    byte unsigned m_rexp [MB];

    function automatic int m_off();
        return (m_done == 0) ? (m_start % LB) : 0;
    endfunction

    function automatic int m_clen();
        int rem;
        rem = m_len - m_done;
        return (rem < LB - m_off()) ? rem : LB - m_off();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_issuing = 0; m_retry = 0; m_drain = 0;
            e_rsp = 0; e_retry = 0; e_drain = 0; e_bad = 0;
        end else begin
            e_rsp = 0; e_retry = 0; e_drain = 0; e_bad = 0;
            if (!m_busy) begin
                if (drain_req) e_drain = 1;
                if (req_valid) begin
                    if (req_len == 0) begin
                        e_bad = 1;
                    end else begin
                        m_busy = 1; m_issuing = 1; m_done = 0; m_issued = 0;
                        m_start = int'(req_addr); m_len = int'(req_len);
                        m_wr = req_write; m_need = req_need_rsp;
                        for (int i = 0; i < MB; i++) begin
                            m_pay[i] = req_wdata[8*i +: 8];
                            m_rexp[i] = gold[(m_start + i) % MEMSZ];
                        end
                        if (m_wr) begin
                            for (int i = 0; i < m_len; i++) gold[(m_start + i) % MEMSZ] = m_pay[i];
                        end
                    end
                end
            end else begin
                if (req_valid) m_retry = 1;
                if (drain_req) m_drain = 1;
                if (m_issuing) begin
                    if (ds_ready) begin
                        m_issued = m_issued + m_clen();
                        m_issuing = 0;
                    end
                end else if (ds_done) begin
                    m_done = m_issued;
                    if (m_done == m_len) begin
                        m_busy = 0;
                        e_rsp = m_need;
                        e_retry = m_retry; m_retry = 0;
                        e_drain = m_drain; m_drain = 0;
                    end else begin
                        m_issuing = 1;
                    end
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(req_ready == !m_busy, "R2 req_ready", req_ready, !m_busy);
            chk(ds_valid == (m_busy && m_issuing), "R7 ds_valid", ds_valid, m_busy && m_issuing);
            chk(rsp_valid == e_rsp, "R10 rsp_valid", rsp_valid, e_rsp);
            chk(retry_pulse == e_retry, "R9 retry_pulse", retry_pulse, e_retry);
            chk(drain_done == e_drain, "R11 drain_done", drain_done, e_drain);
            chk(req_bad == e_bad, "R12 req_bad", req_bad, e_bad);
            if (ds_valid && m_busy && m_issuing) begin
                if (m_done == 0) begin
                    chk(int'(ds_addr) == m_start, "R3 first addr", ds_addr, m_start);
                    chk(int'(ds_len) == m_clen(), "R3 first len", ds_len, m_clen());
                end else begin
                    chk(int'(ds_addr) == m_start + m_done, "R4 later addr", ds_addr, m_start + m_done);
                    chk(int'(ds_len) == m_clen(), "R4 later len", ds_len, m_clen());
                end
                chk(ds_write == m_wr, "R5 ds_write", ds_write, m_wr);
                for (int b = 0; b < LB; b++) begin
                    bit en;
                    en = (b >= m_off()) && (b < m_off() + m_clen());
                    if (ds_be[b] != en) chk(0, "R3 ds_be lane", ds_be[b], en);
                    if (en && m_wr && ds_wdata[8*b +: 8] != m_pay[m_done + b - m_off()])
                        chk(0, "R5 wdata lane", ds_wdata[8*b +: 8], m_pay[m_done + b - m_off()]);
                end
            end
            if (rsp_valid && e_rsp && !m_wr) begin
                bit ok;
                ok = 1;
                for (int i = 0; i < m_len; i++)
                    if (rsp_rdata[8*i +: 8] != m_rexp[i]) ok = 0;
                chk(ok, "R6 read gather", rsp_rdata[63:0], {m_rexp[7], m_rexp[6], m_rexp[5],
                    m_rexp[4], m_rexp[3], m_rexp[2], m_rexp[1], m_rexp[0]});
            end
        end
    end

    // downstream memory responder
    int rdy_mode = 0;
    int lat_cfg = 0;
    int cyc = 0;
    bit have_chunk = 0;
    int lat_cnt = 0;
    int c_base = 0;
    bit c_wr = 0;
    logic [LB-1:0]   c_be;
    logic [LB*8-1:0] c_wdata;

    always @(negedge clk) begin
        cyc++;
        ds_done = 1'b0;
        if (have_chunk) begin
            if (lat_cnt == 0) begin
                for (int b = 0; b < LB; b++) begin
                    if (c_wr && c_be[b]) mem[c_base + b] = c_wdata[8*b +: 8];
                    ds_rdata[8*b +: 8] = mem[c_base + b];
                end
                ds_done = 1'b1;
                have_chunk = 0;
            end else begin
                lat_cnt--;
            end
        end
        ds_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
        if (ds_valid && ds_ready && !have_chunk) begin
            have_chunk = 1;
            lat_cnt = lat_cfg;
            c_base = (int'(ds_addr) / LB * LB) % MEMSZ;
            c_wr = ds_write;
            c_be = ds_be;
            c_wdata = ds_wdata;
        end
    end

    task automatic load_req(input int addr, input int len, input bit wr, input bit need, input int seed);
        req_addr = AW'(addr);
        req_len = LW'(len);
        req_write = wr;
        req_need_rsp = need;
        for (int i = 0; i < MB; i++) req_wdata[8*i +: 8] = 8'((seed * 7 + i * 13) & 255);
        req_valid = 1'b1;
    endtask

    task automatic send(input int addr, input int len, input bit wr, input bit need, input int seed);
        @(negedge clk);
        load_req(addr, len, wr, need, seed);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (m_busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_final_done();
        forever begin
            @(negedge clk);
            #1;
            if (m_busy && !m_issuing && ds_done && (m_issued == m_len)) break;
        end
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) begin
            mem[i] = 8'((i * 5 + 1) & 255);
            gold[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1: idle outputs while reset is held
        chk(req_ready == 1'b1, "R1 req_ready in reset", req_ready, 1);
        chk(ds_valid == 1'b0, "R1 ds_valid in reset", ds_valid, 0);
        chk(rsp_valid == 1'b0 && retry_pulse == 1'b0, "R1 rsp/retry in reset", {rsp_valid, retry_pulse}, 0);
        chk(drain_done == 1'b0 && req_bad == 1'b0, "R1 drain/bad in reset", {drain_done, req_bad}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R3 R6: aligned single-line read
        send(32'h40, 64, 0, 1, 1); wait_idle();
        // R3 R4 R6: unaligned read across two lines
        send(32'h13, 100, 0, 1, 2); wait_idle();
        // R4 R5 R8: unaligned write over four lines with stalls
        rdy_mode = 1; lat_cfg = 2;
        send(32'h1F0, 200, 1, 1, 3); wait_idle();
        // R3: short access inside one line
        send(32'h105, 10, 0, 1, 4); wait_idle();
        // R6: maximum length, odd offset
        rdy_mode = 0; lat_cfg = 1;
        send(32'h303, 256, 0, 1, 5); wait_idle();
        // R12: zero length
        send(32'h80, 0, 0, 1, 6); wait_idle();
        // R10: write without response
        send(32'h500, 90, 1, 0, 7); wait_idle();
        // R9 R2: refused request mid-transfer, then retried
        lat_cfg = 3;
        send(32'h200, 130, 1, 1, 8);
        repeat (2) @(negedge clk);
        send(32'h10, 8, 0, 1, 9);
        wait_idle();
        // R11: drain while idle
        @(negedge clk); drain_req = 1'b1; @(negedge clk); drain_req = 1'b0;
        wait_idle();
        // R11: drain during a transfer
        send(32'h600, 150, 0, 1, 10);
        @(negedge clk); drain_req = 1'b1; @(negedge clk); drain_req = 1'b0;
        wait_idle();
        // R9 R11 R10: refusal and drain in the final completion cycle
        lat_cfg = 2; rdy_mode = 1;
        send(32'h320, 70, 0, 1, 11);
        wait_final_done();
        load_req(32'h44, 20, 1, 1, 12);
        drain_req = 1'b1;
        @(negedge clk);
        drain_req = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();

        // R5: memory image written through the block equals the intended image
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < MEMSZ; i++) if (mem[i] != gold[i]) bad++;
            chk(bad == 0, "R5 memory image mismatches", bad, 0);
        end
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL R7 watchdog expired actual=%0d expected=done", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule